// File: doc/BRIEF.md
# Cache Line Refill Burst Engine

This block fills one cache line from memory after a miss. A requester hands it the address that missed and the way that has been chosen to receive the line. The engine rounds the address down to the start of its line and issues one incrementing read burst on an AXI4 read address channel. It then accepts the returned data beats on the read data channel. Each beat carries one bus-width subline, and it is written straight into the matching slot of the cache data array. The engine supplies the way, the set, the subline number and a one-hot subline write enable with each beat.

With the default parameters a line is 128 bytes. It is split into eight 16-byte sublines, one for each beat of a 128-bit bus. The cache has 128 lines in four ways, which gives 32 sets. After the last beat the engine reports completion for one cycle, together with an error indication. The error is set if any beat came back with a non-OKAY response, or if the burst-end marker did not fall exactly on the final beat. A new miss is taken only in the idle state or in the completion cycle itself, so refills never overlap.

Top module: `line_fill_engine`

## Requirements
- R1: While reset is active and directly after it, the engine is idle: miss_ready is 1, and ar_valid, r_ready, wr_en and done_valid are 0.
- R2: A read request carries ar_addr equal to the miss address with bits [6:0] cleared, ar_len = 7 (eight beats), ar_size = 4 (16 bytes per beat) and ar_burst = 2'b01 (incrementing). ar_valid rises in the cycle after the miss is accepted.
- R3: Once raised, ar_valid stays high with an unchanged ar_addr until the cycle in which ar_ready is high. It falls in the following cycle.
- R4: miss_ready is 0 from the cycle after a miss is accepted until the completion cycle. A miss presented during that time is neither taken nor does it change the refill in progress.
- R5: r_ready is 1 from the cycle after the address handshake until the eighth beat is accepted. Each accepted beat gives wr_en = 1 with wr_data = r_data, the miss way, the set index (miss address bits [11:7]), and wr_sub counting 0 to 7 in arrival order. wr_sub_en is one-hot with bit wr_sub set. wr_en is 0 in every other cycle.
- R6: done_valid is high for exactly one cycle, the cycle after the eighth beat is accepted. In that cycle it presents the way and set of the refill.
- R7: done_err is 1 in the completion cycle if any beat of that refill had r_resp other than 2'b00.
- R8: done_err is 1 if r_last is 0 on the eighth beat or 1 on an earlier beat. Completion still follows exactly eight accepted beats.
- R9: The error indication belongs to one refill only. It is cleared when a new miss is accepted.
- R10: A miss presented in the completion cycle is accepted in that cycle. Its read request follows in the next cycle, while the finished refill is still reported with its own way, set and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Engine can take a miss this cycle |
| miss_addr | input | 32 | Byte address that missed |
| miss_way | input | 2 | Way that receives the line |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted by memory |
| ar_addr | output | 32 | Line-aligned burst start address |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Log2 of bytes per beat |
| ar_burst | output | 2 | Burst type (incrementing) |
| r_valid | input | 1 | Read data beat valid |
| r_ready | output | 1 | Engine accepts a read beat |
| r_data | input | 128 | Read data beat |
| r_resp | input | 2 | Read response of the beat |
| r_last | input | 1 | Burst-end marker |
| wr_en | output | 1 | Data array subline write strobe |
| wr_way | output | 2 | Way written |
| wr_set | output | 5 | Set written |
| wr_sub | output | 3 | Subline index written |
| wr_sub_en | output | 8 | One-hot subline write enables |
| wr_data | output | 128 | Subline data written |
| done_valid | output | 1 | Refill complete (one-cycle pulse) |
| done_err | output | 1 | Refill saw a response or burst-end error |
| done_way | output | 2 | Way of the finished refill |
| done_set | output | 5 | Set of the finished refill |

## Verification
Completion reporting and the capture of the next miss can fall in the same cycle. The same is true of the error clear of a new refill and the error report of the old one. The bench provokes this in two ways. It keeps a second miss pending for the whole of a refill, and it issues back-to-back refills whose second request arrives exactly in the completion cycle. The cycle-level model then requires three things in that cycle: done_way, done_set and done_err still describe the finished line, the read request for the new line appears one cycle later, and the new refill's error starts clear even when the previous one failed.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

  typedef enum logic [1:0] {
    LFE_IDLE = 2'd0,
    LFE_ADDR = 2'd1,
    LFE_DATA = 2'd2,
    LFE_DONE = 2'd3
  } lfe_state_e;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/lfe_req_reg.sv
module lfe_req_reg #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int SET_W  = 5,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [WAY_W-1:0]  miss_way,
  output logic [ADDR_W-1:0] line_addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [WAY_W-1:0]  way
);

  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] line_q, line_d;
  logic [WAY_W-1:0] way_q, way_d;

  always_comb begin
    line_d = line_q;
    way_d  = way_q;
    if (cap_en) begin
      line_d = miss_addr[ADDR_W-1:OFF_W];
      way_d  = miss_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      way_q  <= '0;
    end else begin
      line_q <= line_d;
      way_q  <= way_d;
    end
  end

  assign line_addr = {line_q, {OFF_W{1'b0}}};
  assign set_idx   = line_q[SET_W-1:0];
  assign way       = way_q;

endmodule

// File: rtl/lfe_beat_track.sv
module lfe_beat_track #(
  parameter int BEATS = 8,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             beat_en,
  input  logic             r_last,
  input  logic [1:0]       r_resp,
  output logic [SUB_W-1:0] sub_idx,
  output logic             final_beat,
  output logic [BEATS-1:0] sub_en,
  output logic             err
);

  import lfe_pkg::*;

  localparam logic [SUB_W-1:0] LAST_IDX = SUB_W'(BEATS - 1);

  logic [SUB_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             beat_bad;

  assign final_beat = (cnt_q == LAST_IDX);
  assign beat_bad   = (r_resp != RESP_OKAY) || (r_last != final_beat);

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (clr) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (beat_en) begin
      cnt_d = final_beat ? '0 : cnt_q + 1'b1;
      err_d = err_q | beat_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_sub_dec
    assign sub_en[g] = beat_en && (cnt_q == SUB_W'(g));
  end

  assign sub_idx = cnt_q;
  assign err     = err_q;

endmodule

// File: rtl/lfe_ctrl.sv
module lfe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic ar_ready,
  input  logic r_valid,
  input  logic final_beat,
  output logic miss_ready,
  output logic cap_en,
  output logic ar_valid,
  output logic r_ready,
  output logic beat_en,
  output logic done_valid
);

  import lfe_pkg::*;

  lfe_state_e state_q, state_d;

  assign miss_ready = (state_q == LFE_IDLE) || (state_q == LFE_DONE);
  assign cap_en     = miss_valid && miss_ready;
  assign ar_valid   = (state_q == LFE_ADDR);
  assign r_ready    = (state_q == LFE_DATA);
  assign beat_en    = r_valid && r_ready;
  assign done_valid = (state_q == LFE_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LFE_IDLE: if (cap_en) state_d = LFE_ADDR;
      LFE_ADDR: if (ar_ready) state_d = LFE_DATA;
      LFE_DATA: if (beat_en && final_beat) state_d = LFE_DONE;
      LFE_DONE: state_d = cap_en ? LFE_ADDR : LFE_IDLE;
      default:  state_d = LFE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LFE_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int BEATS  = 8,
  parameter int WAYS   = 4,
  parameter int LINES  = 128,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int OFF_W      = $clog2(BEAT_BYTES * BEATS),
  localparam int WAY_W      = $clog2(WAYS),
  localparam int SET_W      = $clog2(LINES / WAYS),
  localparam int SUB_W      = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [WAY_W-1:0]  miss_way,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              wr_en,
  output logic [WAY_W-1:0]  wr_way,
  output logic [SET_W-1:0]  wr_set,
  output logic [SUB_W-1:0]  wr_sub,
  output logic [BEATS-1:0]  wr_sub_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_valid,
  output logic              done_err,
  output logic [WAY_W-1:0]  done_way,
  output logic [SET_W-1:0]  done_set
);

  import lfe_pkg::*;

  logic             cap_en;
  logic             beat_en;
  logic             final_beat;
  logic             err;
  logic [SET_W-1:0] set_idx;
  logic [WAY_W-1:0] way;

  lfe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .ar_ready   (ar_ready),
    .r_valid    (r_valid),
    .final_beat (final_beat),
    .miss_ready (miss_ready),
    .cap_en     (cap_en),
    .ar_valid   (ar_valid),
    .r_ready    (r_ready),
    .beat_en    (beat_en),
    .done_valid (done_valid)
  );

  lfe_req_reg #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SET_W  (SET_W),
    .WAY_W  (WAY_W)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .miss_addr (miss_addr),
    .miss_way  (miss_way),
    .line_addr (ar_addr),
    .set_idx   (set_idx),
    .way       (way)
  );

  lfe_beat_track #(
    .BEATS (BEATS),
    .SUB_W (SUB_W)
  ) u_beats (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cap_en),
    .beat_en    (beat_en),
    .r_last     (r_last),
    .r_resp     (r_resp),
    .sub_idx    (wr_sub),
    .final_beat (final_beat),
    .sub_en     (wr_sub_en),
    .err        (err)
  );

  assign ar_len   = 8'(BEATS - 1);
  assign ar_size  = 3'($clog2(BEAT_BYTES));
  assign ar_burst = BURST_INCR;

  assign wr_en    = beat_en;
  assign wr_way   = way;
  assign wr_set   = set_idx;
  assign wr_data  = r_data;

  assign done_err = err;
  assign done_way = way;
  assign done_set = set_idx;

endmodule

// File: rtl/lfe_checker.sv
module lfe_checker #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 8,
  parameter int OFF_W  = 7,
  parameter int SUB_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic [2:0]        ar_size,
  input logic [1:0]        ar_burst,
  input logic              r_ready,
  input logic              wr_en,
  input logic [SUB_W-1:0]  wr_sub,
  input logic [BEATS-1:0]  wr_sub_en,
  input logic              done_valid
);

  logic [SUB_W:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen_q <= '0;
    else if (ar_valid && ar_ready) seen_q <= '0;
    else if (wr_en)              seen_q <= seen_q + 1'b1;
  end

  a_r2_burst_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_addr[OFF_W-1:0] == '0) && (ar_len == 8'(BEATS - 1)) &&
                 (ar_size == 3'd4) && (ar_burst == 2'b01));

  a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> ar_valid && $stable(ar_addr));

  a_r3_ar_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !ar_valid);

  a_r4_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid || r_ready) |-> !miss_ready);

  a_r5_onehot_en: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_sub_en) == 1) && wr_sub_en[wr_sub] && r_ready);

  a_r5_no_stray_en: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_sub_en == '0));

  a_r5_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sub == seen_q[SUB_W-1:0]));

  a_r6_done_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (seen_q == (SUB_W+1)'(BEATS)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

endmodule

bind line_fill_engine lfe_checker #(
  .ADDR_W (ADDR_W),
  .BEATS  (BEATS),
  .OFF_W  (OFF_W),
  .SUB_W  (SUB_W)
) u_lfe_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_ready (miss_ready),
  .ar_valid   (ar_valid),
  .ar_ready   (ar_ready),
  .ar_addr    (ar_addr),
  .ar_len     (ar_len),
  .ar_size    (ar_size),
  .ar_burst   (ar_burst),
  .r_ready    (r_ready),
  .wr_en      (wr_en),
  .wr_sub     (wr_sub),
  .wr_sub_en  (wr_sub_en),
  .done_valid (done_valid)
);

// File: tb/tb_line_fill_engine.sv
module tb_line_fill_engine;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         miss_valid, miss_ready;
  logic [31:0]  miss_addr;
  logic [1:0]   miss_way;
  logic         ar_valid, ar_ready;
  logic [31:0]  ar_addr;
  logic [7:0]   ar_len;
  logic [2:0]   ar_size;
  logic [1:0]   ar_burst;
  logic         r_valid, r_ready;
  logic [127:0] r_data;
  logic [1:0]   r_resp;
  logic         r_last;
  logic         wr_en;
  logic [1:0]   wr_way;
  logic [4:0]   wr_set;
  logic [2:0]   wr_sub;
  logic [7:0]   wr_sub_en;
  logic [127:0] wr_data;
  logic         done_valid, done_err;
  logic [1:0]   done_way;
  logic [4:0]   done_set;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_fill_engine dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_way(miss_way),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_sub(wr_sub),
    .wr_sub_en(wr_sub_en), .wr_data(wr_data),
    .done_valid(done_valid), .done_err(done_err),
    .done_way(done_way), .done_set(done_set)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string ctx = "reset";

  // Behavioural reference: phase 0 idle, 1 address, 2 data, 3 completion
  int          m_ph;
  logic [31:0] m_addr;
  logic [1:0]  m_way;
  int          m_cnt;
  bit          m_err;

  // Miss kept on the request port while a refill is busy (R4)
  bit          pv = 0;
  logic [31:0] pa = '0;
  logic [1:0]  pw = '0;

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t got %h exp %h", req, ctx, $time, got, exp);
    end
  endtask

  task automatic compare();
    logic exp_wr;
    exp_wr = (m_ph == 2) && r_valid;
    chk("R4 miss_ready", 128'(miss_ready), 128'((m_ph == 0) || (m_ph == 3)));
    chk("R3 ar_valid", 128'(ar_valid), 128'(m_ph == 1));
    if (m_ph == 1) begin
      chk("R2 ar_addr", 128'(ar_addr), 128'({m_addr[31:7], 7'd0}));
      chk("R2 ar_len", 128'(ar_len), 128'(7));
      chk("R2 ar_size", 128'(ar_size), 128'(4));
      chk("R2 ar_burst", 128'(ar_burst), 128'(1));
    end
    chk("R5 r_ready", 128'(r_ready), 128'(m_ph == 2));
    chk("R5 wr_en", 128'(wr_en), 128'(exp_wr));
    chk("R5 wr_sub_en", 128'(wr_sub_en), exp_wr ? 128'(8'd1 << m_cnt) : 128'(0));
    if (exp_wr) begin
      chk("R5 wr_sub", 128'(wr_sub), 128'(m_cnt));
      chk("R5 wr_way", 128'(wr_way), 128'(m_way));
      chk("R5 wr_set", 128'(wr_set), 128'(m_addr[11:7]));
      chk("R5 wr_data", wr_data, r_data);
    end
    chk("R6 done_valid", 128'(done_valid), 128'(m_ph == 3));
    if (m_ph == 3) begin
      chk("R6 done_way", 128'(done_way), 128'(m_way));
      chk("R6 done_set", 128'(done_set), 128'(m_addr[11:7]));
      chk("R7 R8 R9 done_err", 128'(done_err), 128'(m_err));
    end
  endtask

  task automatic model_edge();
    case (m_ph)
      0, 3: begin
        if (miss_valid) begin
          m_addr = miss_addr; m_way = miss_way; m_err = 0; m_ph = 1;
        end else m_ph = 0;
      end
      1: if (ar_ready) begin m_ph = 2; m_cnt = 0; end
      2: if (r_valid) begin
        if (r_resp != 2'b00 || r_last != (m_cnt == 7)) m_err = 1;
        if (m_cnt == 7) m_ph = 3;
        else m_cnt++;
      end
      default: m_ph = 0;
    endcase
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  // One refill: arw = address wait cycles, gap = idle cycles between beats,
  // badb = beat with error response, lastb = beat carrying r_last,
  // nxt = leave the completion cycle for the next refill call (R10)
  task automatic refill(input logic [31:0] a, input logic [1:0] w, input int arw,
                        input int gap, input int badb, input int lastb, input bit nxt);
    bit acc, hs;
    int b, cyc;
    miss_valid = 1; miss_addr = a; miss_way = w;
    forever begin
      acc = (m_ph == 0) || (m_ph == 3);
      step();
      if (acc) break;
    end
    miss_valid = pv; miss_addr = pa; miss_way = pw;
    for (int c = 0; ; c++) begin
      ar_ready = (c >= arw);
      hs = ar_ready && (m_ph == 1);
      step();
      if (hs) break;
    end
    ar_ready = 0;
    b = 0; cyc = 0;
    while (b < 8) begin
      r_valid = (gap == 0) || (cyc % (gap + 1) == 0);
      r_data  = {$urandom, $urandom, $urandom, $urandom};
      r_resp  = (b == badb) ? 2'b10 : 2'b00;
      r_last  = (b == lastb);
      step();
      if (r_valid) b++;
      cyc++;
    end
    r_valid = 0; r_last = 0; r_resp = 0;
    if (!nxt) begin
      miss_valid = 0;
      step();
      step();
    end
  endtask

  initial begin
    rst_n = 0; miss_valid = 0; miss_addr = '0; miss_way = '0;
    ar_ready = 0; r_valid = 0; r_data = '0; r_resp = 0; r_last = 0;
    m_ph = 0; m_addr = '0; m_way = '0; m_cnt = 0; m_err = 0;
    @(negedge clk);
    // R1: idle outputs while reset is held
    repeat (3) begin #1 compare(); @(negedge clk); end
    rst_n = 1;
    ctx = "R1 after reset"; step();

    ctx = "R2 R5 R6 plain";      refill(32'h1234_5678, 2'd2, 0, 0, -1, 7, 0);
    ctx = "R3 ar wait, R5 gaps"; refill(32'h0000_0F80, 2'd1, 3, 1, -1, 7, 0);
    ctx = "R7 bad resp";         refill(32'hABCD_0123, 2'd0, 1, 0, 3, 7, 0);
    ctx = "R8 early last";       refill(32'h8000_0040, 2'd3, 0, 2, -1, 5, 0);
    ctx = "R8 missing last";     refill(32'h7FFF_FF80, 2'd2, 0, 0, -1, -1, 0);
    ctx = "R9 clean after error"; refill(32'h0000_0000, 2'd1, 0, 0, -1, 7, 0);
    ctx = "R2 all low bits set"; refill(32'hFFFF_FFFF, 2'd3, 2, 0, -1, 7, 0);

    // R4: a second miss waits on the port for the whole refill, R10: taken at completion
    pv = 1; pa = 32'h5555_5A5A; pw = 2'd0;
    ctx = "R4 pending miss";     refill(32'h2222_2222, 2'd1, 2, 1, 6, 7, 1);
    pv = 0;
    ctx = "R10 R9 back to back"; refill(32'h5555_5A5A, 2'd0, 0, 0, -1, 7, 1);
    ctx = "R10 chain err";       refill(32'h3333_3300, 2'd2, 0, 0, 0, 7, 1);
    ctx = "R10 R9 chain clean";  refill(32'h4444_4480, 2'd3, 1, 0, -1, 7, 0);

    for (int i = 0; i < 12; i++) begin
      ctx = "R5 R6 mixed";
      refill($urandom, 2'($urandom), i % 3, i % 2, (i % 4 == 0) ? int'(i % 8) : -1,
             (i % 5 == 1) ? 4 : 7, (i % 3 == 2));
    end
    miss_valid = 0;
    step(); step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired (%s)", ctx);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule